// File: doc/BRIEF.md
# Per-Output Reference Clock Gate

This block takes one reference clock and hands out eight gated copies of it, each as a true and complement pair. Every output can be started or stopped on its own, and the switch never produces a shortened pulse. A pair is enabled only when two conditions agree: its active-low hardware enable pin is low, and its active-high software enable bit is set. A pair that is disabled drives both lines low rather than letting them float.

A single active-low power input does two jobs. Its first rising edge after reset captures the static configuration, which is the frequency-select pin and the already-decoded bandwidth/bypass mode. From then on the same input acts as a power-down control. When it is seen low on two consecutive rising edges of the complement clock, all outputs go to a tri-state flag on the next falling edge of that complement clock. A later rising edge brings the outputs back.

The block itself runs on the reference clock. The true phase toggles on every cycle, so each output runs at half the reference rate. All asynchronous pins pass through a synchronizer before any logic uses them.

Top module: `clk_gate_ctrl`

## Requirements
- R1: A pair is enabled exactly when its hardware pin `oe_n[i]` is 0 and its software bit `sw_en[i]` is 1. A software bit of 0 disables the pair whatever the pin does.
- R2: A disabled pair drives `clk_t[i]` = 0 and `clk_c[i]` = 0. The two lines are never high in the same cycle.
- R3: The true phase resets to 0 and toggles on every cycle after reset, starting high on the first cycle after reset release. An enabled pair that is not in tri-state gives `clk_t[i]` equal to that phase and `clk_c[i]` equal to its inverse.
- R4: A change on a hardware enable pin is not visible on its pair for at least the first 3 clock edges after the change. It is visible after at most 8 edges.
- R5: Gating changes take effect only on the edge where the true line enters its low phase. As a result, every rise of `clk_t[i]` follows a cycle in which `clk_c[i]` was high.
- R6: After the power input has been high once, it is sampled low on two consecutive complement rising edges. The tri-state flag `out_hiz` then rises on the next complement falling edge, within 10 edges of the pin falling. A low pulse of 2 cycles or less causes no tri-state. While `out_hiz` is 1, all `clk_t` and `clk_c` lines are 0.
- R7: The first rising edge of the power input latches `freq_sel` into `cfg_freq` and the mode into `cfg_mode_rb`, and sets `cfg_valid`. Later edges and later pin changes leave these outputs unchanged.
- R8: `mode_in` uses this code: 00 is low bandwidth, 01 is bypass, 10 is high bandwidth, and 11 is treated as bypass. It reads back on `cfg_mode_rb` as 00 for low bandwidth, 01 for bypass and 11 for high bandwidth.
- R9: From reset until the first rising edge of the power input, `out_hiz` is 1, `cfg_valid` is 0 and all outputs are 0.
- R10: After a power-down, a rising edge on the power input clears `out_hiz` within 8 edges, and the enabled pairs run again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok_n_pd | input | 1 | Power good on its first rise; active-low power-down after that (asynchronous) |
| oe_n | input | N_OUT | Active-low hardware enable, one per pair (asynchronous) |
| sw_en | input | N_OUT | Active-high software enable, one per pair |
| freq_sel | input | 1 | Frequency-select pin, sampled once |
| mode_in | input | 2 | Decoded bandwidth/bypass mode, sampled once |
| clk_t | output | N_OUT | Gated true clock values |
| clk_c | output | N_OUT | Gated complement clock values |
| out_hiz | output | 1 | All outputs are in tri-state |
| cfg_valid | output | 1 | Configuration has been latched |
| cfg_freq | output | 1 | Latched frequency select |
| cfg_mode_rb | output | 2 | Mode readback code |

## Verification
The assertions check the following on every cycle:
- the two lines of a pair are never high together;
- all outputs are quiet while tri-stated;
- the tri-state flag is held until the configuration is latched;
- a true rise always follows a full complement high phase;
- the tri-state flag rises only at a complement falling edge;
- the latched configuration never moves once it is valid.

The bench's scenarios are needed for the rest:
- the enable truth table over every pin pattern;
- the 4-to-8 edge latency window, seen from both clock phases;
- rejection of a short power-down pulse;
- the full power-down and recovery sequence;
- each mode readback code.

// File: rtl/clk_gate_pkg.sv
package clk_gate_pkg;
  typedef enum logic [1:0] {
    MODE_LOW_BW  = 2'b00,
    MODE_BYPASS  = 2'b01,
    MODE_HIGH_BW = 2'b10,
    MODE_RSVD    = 2'b11
  } mode_e;

  // R8: readback code of a decoded mode
  function automatic logic [1:0] mode_readback(input logic [1:0] mode);
    case (mode)
      MODE_LOW_BW:  mode_readback = 2'b00;
      MODE_HIGH_BW: mode_readback = 2'b11;
      default:      mode_readback = 2'b01;
    endcase
  endfunction

  // R1: combined enable of one pair
  function automatic logic pair_enable(input logic pin_n, input logic sw);
    pair_enable = ~pin_n & sw;
  endfunction
endpackage

// File: rtl/cg_sync.sv
module cg_sync #(
  parameter int WIDTH   = 1,
  parameter int STAGES  = 3,
  parameter logic RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= {WIDTH{RST_VAL}};
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= {WIDTH{RST_VAL}};
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cg_chan.sv
module cg_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n_s,
  input  logic sw,
  input  logic ref_ph,
  input  logic hiz,
  output logic out_t,
  output logic out_c
);
  import clk_gate_pkg::*;

  logic want_en;
  logic gate_en;
  logic apply_edge;

  assign want_en    = pair_enable(pin_n_s, sw);
  // next edge brings the true line low: the only edge where gating may change
  assign apply_edge = ref_ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          gate_en <= 1'b0;
    else if (apply_edge) gate_en <= want_en;
  end

  assign out_t = gate_en & ~hiz & ref_ph;
  assign out_c = gate_en & ~hiz & ~ref_ph;
endmodule

// File: rtl/cg_power.sv
module cg_power (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pg_s,
  input  logic       ref_ph,
  input  logic       freq_sel,
  input  logic [1:0] mode_in,
  output logic       hiz,
  output logic       started,
  output logic       cfg_freq,
  output logic [1:0] cfg_mode_rb
);
  import clk_gate_pkg::*;

  localparam int CNT_W = 2;
  localparam logic [CNT_W-1:0] PD_HITS = CNT_W'(2);

  logic             pg_d;
  logic             pg_rise;
  logic [CNT_W-1:0] low_hits;
  logic             comp_rise_edge;
  logic             comp_fall_edge;
  logic             enter_hiz;
  logic             leave_hiz;

  assign pg_rise        = pg_s & ~pg_d;
  assign comp_rise_edge = ref_ph;
  assign comp_fall_edge = ~ref_ph;
  assign enter_hiz = ~hiz & started & ~pg_s & comp_fall_edge & (low_hits == PD_HITS);
  assign leave_hiz = hiz & started & pg_s & comp_rise_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_d        <= 1'b0;
      started     <= 1'b0;
      cfg_freq    <= 1'b0;
      cfg_mode_rb <= 2'b00;
    end else begin
      pg_d <= pg_s;
      if (pg_rise && !started) begin
        started     <= 1'b1;
        cfg_freq    <= freq_sel;
        cfg_mode_rb <= mode_readback(mode_in);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    low_hits <= '0;
    else if (pg_s || !started)                     low_hits <= '0;
    else if (comp_rise_edge && low_hits != PD_HITS) low_hits <= low_hits + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hiz <= 1'b1;
    else if (enter_hiz) hiz <= 1'b1;
    else if (leave_hiz) hiz <= 1'b0;
  end
endmodule

// File: rtl/clk_gate_ctrl.sv
module clk_gate_ctrl #(
  parameter int N_OUT       = 8,
  parameter int SYNC_STAGES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_ok_n_pd,
  input  logic [N_OUT-1:0] oe_n,
  input  logic [N_OUT-1:0] sw_en,
  input  logic             freq_sel,
  input  logic [1:0]       mode_in,
  output logic [N_OUT-1:0] clk_t,
  output logic [N_OUT-1:0] clk_c,
  output logic             out_hiz,
  output logic             cfg_valid,
  output logic             cfg_freq,
  output logic [1:0]       cfg_mode_rb
);
  logic             ref_ph;
  logic             pg_s;
  logic [N_OUT-1:0] oe_n_s;
  logic             started;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_ph <= 1'b0;
    else        ref_ph <= ~ref_ph;
  end

  cg_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pg_sync (
    .clk(clk), .rst_n(rst_n), .d(pwr_ok_n_pd), .q(pg_s));

  cg_sync #(.WIDTH(N_OUT), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_oe_sync (
    .clk(clk), .rst_n(rst_n), .d(oe_n), .q(oe_n_s));

  cg_power u_power (
    .clk(clk), .rst_n(rst_n), .pg_s(pg_s), .ref_ph(ref_ph),
    .freq_sel(freq_sel), .mode_in(mode_in), .hiz(out_hiz),
    .started(started), .cfg_freq(cfg_freq), .cfg_mode_rb(cfg_mode_rb));

  for (genvar i = 0; i < N_OUT; i++) begin : g_pair
    cg_chan u_chan (
      .clk(clk), .rst_n(rst_n), .pin_n_s(oe_n_s[i]), .sw(sw_en[i]),
      .ref_ph(ref_ph), .hiz(out_hiz), .out_t(clk_t[i]), .out_c(clk_c[i]));
  end

  assign cfg_valid = started;
endmodule

// File: rtl/clk_gate_ctrl_chk.sv
module clk_gate_ctrl_chk #(
  parameter int N_OUT = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_OUT-1:0] clk_t,
  input logic [N_OUT-1:0] clk_c,
  input logic             out_hiz,
  input logic             cfg_valid,
  input logic             cfg_freq,
  input logic [1:0]       cfg_mode_rb,
  input logic             ref_ph
);
  assert_pair_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_t & clk_c) == '0);

  assert_hiz_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_hiz |-> ((clk_t | clk_c) == '0));

  assert_hiz_on_comp_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_hiz) |-> $past(!ref_ph));

  assert_boot_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |-> out_hiz);

  assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && $past(cfg_valid)) |-> ($stable(cfg_freq) && $stable(cfg_mode_rb)));

  assert_mode_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode_rb != 2'b10);

  for (genvar i = 0; i < N_OUT; i++) begin : g_pulse
    assert_full_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_t[i]) |-> $past(clk_c[i]));
  end
endmodule

bind clk_gate_ctrl clk_gate_ctrl_chk #(.N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_t(clk_t), .clk_c(clk_c), .out_hiz(out_hiz),
  .cfg_valid(cfg_valid), .cfg_freq(cfg_freq), .cfg_mode_rb(cfg_mode_rb),
  .ref_ph(ref_ph));

// File: tb/clk_gate_ctrl_tb.sv
module clk_gate_ctrl_tb;
  localparam int N = 8;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pg = 1'b0;
  logic [N-1:0] oe_n = '0;
  logic [N-1:0] sw_en = '1;
  logic         freq_sel = 1'b1;
  logic [1:0]   mode_in = 2'b10;
  logic [N-1:0] clk_t, clk_c;
  logic         out_hiz, cfg_valid, cfg_freq;
  logic [1:0]   cfg_mode_rb;
  logic         ph;
  int           checks = 0;
  int           errors = 0;
  bit           done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // independent reference phase model (R3)
  always @(posedge clk or negedge rst_n)
    if (!rst_n) ph <= 1'b0; else ph <= ~ph;

  clk_gate_ctrl #(.N_OUT(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_ok_n_pd(pg), .oe_n(oe_n), .sw_en(sw_en),
    .freq_sel(freq_sel), .mode_in(mode_in), .clk_t(clk_t), .clk_c(clk_c),
    .out_hiz(out_hiz), .cfg_valid(cfg_valid), .cfg_freq(cfg_freq),
    .cfg_mode_rb(cfg_mode_rb));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [1:0] rb_of(input logic [1:0] m);
    if (m == 2'b00) return 2'b00;
    if (m == 2'b10) return 2'b11;
    return 2'b01;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; pg = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic check_outputs(input string req);
    logic [N-1:0] en;
    en = ~oe_n & sw_en;
    check({req, " true"}, 32'(clk_t), 32'(en & {N{ph}}));
    check({req, " comp"}, 32'(clk_c), 32'(en & {N{~ph}}));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R9: boot state before the first power rise
    step(10);
    check("R9 hiz", 32'(out_hiz), 32'd1);
    check("R9 valid", 32'(cfg_valid), 32'd0);
    check("R9 outputs", 32'({clk_t, clk_c}), 32'd0);

    // R7, R8: first rise latches configuration
    pg = 1'b1;
    step(12);
    check("R7 valid", 32'(cfg_valid), 32'd1);
    check("R7 freq", 32'(cfg_freq), 32'd1);
    check("R8 high bw code", 32'(cfg_mode_rb), 32'(2'b11));
    check("R10 hiz cleared at start", 32'(out_hiz), 32'd0);

    // R1, R2, R3: sweep all pin patterns against a varied software mask
    for (int v = 0; v < 256; v++) begin
      oe_n  = 8'(v);
      sw_en = {8'(v)} ^ 8'hC3 ^ {8'(v) << 3};
      step(10);
      check_outputs("R1 R2 R3 sweep a");
      step(1);
      check_outputs("R1 R2 R3 sweep b");
    end

    // R4, R5: latency window from both clock phases
    sw_en = '1;
    for (int off = 0; off < 2; off++) begin
      oe_n = '1;
      step(10 + off);
      oe_n[0] = 1'b0;
      step(3);
      check("R4 start not early", 32'(clk_t[0] | clk_c[0]), 32'd0);
      step(5);
      check("R4 start by 8", 32'(clk_t[0] | clk_c[0]), 32'd1);
      step(2);
      oe_n[0] = 1'b1;
      step(3);
      check("R4 stop not early", 32'(clk_t[0] | clk_c[0]), 32'd1);
      step(5);
      check("R4 stop by 8", 32'(clk_t[0] | clk_c[0]), 32'd0);
    end

    // R6: a two-cycle power-down pulse is rejected
    oe_n = 8'h0F; sw_en = '1;
    step(10);
    pg = 1'b0;
    step(2);
    pg = 1'b1;
    for (int k = 0; k < 12; k++) begin
      check("R6 short pulse ignored", 32'(out_hiz), 32'd0);
      step(1);
    end
    check_outputs("R6 still running");

    // R6, R7, R10: full power-down and recovery
    pg = 1'b0;
    step(3);
    check("R6 not early", 32'(out_hiz), 32'd0);
    step(7);
    check("R6 hiz entered", 32'(out_hiz), 32'd1);
    check("R6 quiet", 32'({clk_t, clk_c}), 32'd0);
    freq_sel = 1'b0; mode_in = 2'b00;
    step(5);
    pg = 1'b1;
    step(8);
    check("R10 hiz left", 32'(out_hiz), 32'd0);
    check_outputs("R10 running again");
    check("R7 freq frozen", 32'(cfg_freq), 32'd1);
    check("R7 mode frozen", 32'(cfg_mode_rb), 32'(2'b11));

    // R8: every mode code and frequency value
    for (int m = 0; m < 4; m++) begin
      for (int f = 0; f < 2; f++) begin
        mode_in = 2'(m); freq_sel = 1'(f);
        do_reset();
        pg = 1'b1;
        step(12);
        check("R8 mode readback", 32'(cfg_mode_rb), 32'(rb_of(2'(m))));
        check("R7 freq latch", 32'(cfg_freq), 32'(f));
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule